// File: doc/BRIEF.md
# Byte-wide nonvolatile memory access controller

This block connects a small processor's register bus to a byte-wide nonvolatile data array, modelled here as a plain RAM. Software works through four registers: an address register, a data register, a control register and a status register. To read, software loads the address and sets the read-strobe bit. The controller then halts the processor for a fixed number of cycles and loads the addressed byte into the data register. The strobe bit clears on its own, so software never polls for a read.

A write is a long timed operation. Software loads the address and the data, sets the arm bit, and sets the write-strobe bit within a short window after that. The programming time is counted on a separate fixed-rate oscillator clock. A two-flop synchronizer with a four-phase level handshake carries the request and completion between the two clock domains. While the write is running, the busy bit stays set. Writing the address or data register during that time aborts the write and corrupts the target byte. A low-supply indication blocks new writes, and so does reset. A power-down request that arrives mid-write does not stop the write. It keeps the oscillator enabled until software re-issues the request after the write has finished.

The register bus is a plain single-cycle strobe with no back-pressure. Read data is returned combinationally for the selected register. The only hold-off is `cpu_halt`, and the processor must issue no bus write while it is high.

Top module: `nvm_ctrl`

## Requirements
- R1: Register select 0 is the address register: its low AW bits hold the address and its upper bits read 0. Select 1 is the data register. Select 2 is control: bit 0 is the read strobe, bit 1 the write strobe (it reads 1 while a write is in progress), bit 2 the write arm (it reads 1 while the arm window is open). Select 3 is status: bit 0 busy, bit 1 abort flag, bit 2 read-collision flag, bit 3 power-down hold. Writing 1 to status bit 1 or bit 2 clears that flag.
- R2: A control write with bit 0 set while the controller is idle raises `cpu_halt` from the next cycle for exactly RD_STALL (default 4) cycles. Control bit 0 reads 1 during the stall and 0 after it. When `cpu_halt` falls, the data register holds the array byte at the address register.
- R3: A control write with bit 1 set starts a write only if a control write with bit 2 set (and bit 1 clear) happened at most ARM_WIN (default 4) cycles earlier. A strobe write always consumes the arm window.
- R4: No write starts while `bod_low` is high or while `rst_n` is low.
- R5: From the cycle after an accepted strobe, busy stays set for at least TICKS and at most TICKS+10 periods of `osc_clk`. When busy clears, the array byte at the latched address holds the latched data.
- R6: A rejected write strobe leaves busy at 0, control bit 1 at 0, and the array unchanged.
- R7: A write to the address or data register while a write is in progress aborts that write. The byte at the write's address becomes the bitwise complement of the byte being written, busy then clears, and the abort flag is set.
- R8: A read strobe while busy is ignored: `cpu_halt` stays low and the read-collision flag is set.
- R9: `pd_ack` = `pd_req` and not busy and not hold, and `osc_en` is its inverse. If `pd_req` is high while busy, hold is set and stays set after the write ends until `pd_req` drops.
- R10: After reset, all four registers read 0, `cpu_halt` is 0, and with `pd_req` low `osc_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low asynchronous reset, both domains |
| osc_clk | input | 1 | Fixed-rate programming oscillator clock |
| bus_we | input | 1 | Register write strobe |
| bus_sel | input | 2 | Register select |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Read data of the selected register |
| cpu_halt | output | 1 | Processor hold during a read |
| bod_low | input | 1 | Supply-too-low indication |
| pd_req | input | 1 | Power-down request (level) |
| pd_ack | output | 1 | Full power-down allowed |
| osc_en | output | 1 | Programming oscillator enable |

## Verification
Two functions can land on the same write in the same cycle: a register access from software and the programming operation that is still running. A write to the data register or a read strobe can therefore meet a busy write. The bench provokes this by starting a write and waiting a directed or random number of oscillator periods before it issues the data write or read strobe. An abort is judged by the complemented byte found at the target address, the abort flag, and busy clearing shortly after. A collision is judged by `cpu_halt` staying low, the collision flag being set, and the write then completing with its own data. The arm window and the power-down hold are also probed at their exact boundary cycles.

// File: rtl/nvm_ctrl_pkg.sv
`timescale 1ns/100ps
package nvm_ctrl_pkg;
  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_DATA = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_STAT = 2'd3
  } nvm_sel_e;

  localparam int CTRL_RD  = 0;
  localparam int CTRL_WR  = 1;
  localparam int CTRL_ARM = 2;

  localparam int STAT_BUSY  = 0;
  localparam int STAT_ABORT = 1;
  localparam int STAT_RCOL  = 2;
  localparam int STAT_HOLD  = 3;
endpackage

// File: rtl/nvm_sync2.sv
`timescale 1ns/100ps
module nvm_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= 1'b0;
      q    <= 1'b0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/nvm_rd_stall.sv
`timescale 1ns/100ps
module nvm_rd_stall #(
  parameter int STALL = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active,
  output logic last
);
  localparam int CW = $clog2(STALL + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= CW'(STALL);
    else if (cnt != '0)  cnt <= cnt - CW'(1);
  end

  assign active = (cnt != '0);
  assign last   = (cnt == CW'(1));
endmodule

// File: rtl/nvm_wr_timer.sv
`timescale 1ns/100ps
module nvm_wr_timer #(
  parameter int TICKS = 8448
) (
  input  logic osc_clk,
  input  logic rst_n,
  input  logic run_req,
  output logic run_seen,
  output logic done
);
  localparam int TW = (TICKS > 2) ? $clog2(TICKS) : 2;

  logic          run_s;
  logic [TW-1:0] cnt;

  nvm_sync2 u_sync_run (
    .clk  (osc_clk),
    .rst_n(rst_n),
    .d    (run_req),
    .q    (run_s)
  );

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!run_s) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      if (cnt == TW'(TICKS - 1)) done <= 1'b1;
      else                       cnt  <= cnt + TW'(1);
    end
  end

  assign run_seen = run_s;
endmodule

// File: rtl/nvm_ctrl.sv
`timescale 1ns/100ps
module nvm_ctrl
  import nvm_ctrl_pkg::*;
#(
  parameter int AW       = 7,
  parameter int TICKS    = 8448,
  parameter int RD_STALL = 4,
  parameter int ARM_WIN  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_clk,
  input  logic       bus_we,
  input  logic [1:0] bus_sel,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       cpu_halt,
  input  logic       bod_low,
  input  logic       pd_req,
  output logic       pd_ack,
  output logic       osc_en
);
  localparam int DEPTH = 1 << AW;
  localparam int ACW   = $clog2(ARM_WIN + 1);

  nvm_sel_e      sel;
  logic [AW-1:0] addr_q, wr_addr_q;
  logic [7:0]    data_q, wr_data_q;
  logic [ACW-1:0] arm_cnt;
  logic          run_req, abort_err, rd_col, pd_hold;
  logic          run_seen_o, done_o, ack_s, done_s;
  logic          rd_active, rd_last;
  logic          busy, complete, abort;
  logic          addr_we, data_we, ctrl_we, stat_we;
  logic          rd_start, wr_go;
  logic [7:0]    mem [DEPTH];

  assign sel     = nvm_sel_e'(bus_sel);
  assign addr_we = bus_we && (sel == SEL_ADDR);
  assign data_we = bus_we && (sel == SEL_DATA);
  assign ctrl_we = bus_we && (sel == SEL_CTRL);
  assign stat_we = bus_we && (sel == SEL_STAT);

  // programming timer in the oscillator domain
  nvm_wr_timer #(.TICKS(TICKS)) u_timer (
    .osc_clk (osc_clk),
    .rst_n   (rst_n),
    .run_req (run_req),
    .run_seen(run_seen_o),
    .done    (done_o)
  );

  nvm_sync2 u_sync_ack (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (run_seen_o),
    .q    (ack_s)
  );

  nvm_sync2 u_sync_done (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (done_o),
    .q    (done_s)
  );

  nvm_rd_stall #(.STALL(RD_STALL)) u_stall (
    .clk   (clk),
    .rst_n (rst_n),
    .start (rd_start),
    .active(rd_active),
    .last  (rd_last)
  );

  // busy covers the whole four-phase handshake so a stale done never
  // meets a fresh request
  assign busy     = run_req | ack_s | done_s;
  assign complete = run_req & done_s;
  assign abort    = run_req & ~done_s & (addr_we | data_we);

  assign rd_start = ctrl_we && bus_wdata[CTRL_RD] && !busy && !rd_active;
  assign wr_go    = ctrl_we && bus_wdata[CTRL_WR] && (arm_cnt != '0) &&
                    !busy && !bod_low && !rd_active;

  // array: no reset, contents persist
  always_ff @(posedge clk) begin
    if (complete)   mem[wr_addr_q] <= wr_data_q;
    else if (abort) mem[wr_addr_q] <= ~wr_data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      data_q    <= '0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
      arm_cnt   <= '0;
      run_req   <= 1'b0;
      abort_err <= 1'b0;
      rd_col    <= 1'b0;
      pd_hold   <= 1'b0;
    end else begin
      if (addr_we) addr_q <= bus_wdata[AW-1:0];
      if (rd_last)      data_q <= mem[addr_q];
      else if (data_we) data_q <= bus_wdata;

      if (ctrl_we && bus_wdata[CTRL_WR])       arm_cnt <= '0;
      else if (ctrl_we && bus_wdata[CTRL_ARM]) arm_cnt <= ACW'(ARM_WIN);
      else if (arm_cnt != '0)                  arm_cnt <= arm_cnt - ACW'(1);

      if (wr_go) begin
        run_req   <= 1'b1;
        wr_addr_q <= addr_q;
        wr_data_q <= data_q;
      end else if (complete || abort) begin
        run_req <= 1'b0;
      end

      if (abort)                                  abort_err <= 1'b1;
      else if (stat_we && bus_wdata[STAT_ABORT])  abort_err <= 1'b0;

      if (ctrl_we && bus_wdata[CTRL_RD] && busy)  rd_col <= 1'b1;
      else if (stat_we && bus_wdata[STAT_RCOL])   rd_col <= 1'b0;

      if (!pd_req)   pd_hold <= 1'b0;
      else if (busy) pd_hold <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (sel)
      SEL_ADDR: bus_rdata = 8'(addr_q);
      SEL_DATA: bus_rdata = data_q;
      SEL_CTRL: begin
        bus_rdata[CTRL_RD]  = rd_active;
        bus_rdata[CTRL_WR]  = busy;
        bus_rdata[CTRL_ARM] = (arm_cnt != '0);
      end
      SEL_STAT: begin
        bus_rdata[STAT_BUSY]  = busy;
        bus_rdata[STAT_ABORT] = abort_err;
        bus_rdata[STAT_RCOL]  = rd_col;
        bus_rdata[STAT_HOLD]  = pd_hold;
      end
      default: bus_rdata = '0;
    endcase
  end

  assign cpu_halt = rd_active;
  assign pd_ack   = pd_req & ~busy & ~pd_hold;
  assign osc_en   = ~pd_ack;
endmodule

// File: rtl/nvm_ctrl_chk.sv
`timescale 1ns/100ps
module nvm_ctrl_chk #(
  parameter int RD_STALL = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_we,
  input logic [1:0] bus_sel,
  input logic [7:0] bus_wdata,
  input logic       cpu_halt,
  input logic       bod_low,
  input logic       pd_req,
  input logic       pd_ack,
  input logic       busy,
  input logic       abort_err
);
  logic [7:0] hcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hcnt <= '0;
    else if (!cpu_halt) hcnt <= '0;
    else if (hcnt != 8'hFF) hcnt <= hcnt + 8'd1;
  end

  assert_halt_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_halt) |-> hcnt == 8'(RD_STALL));

  assert_halt_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_halt) |-> $past(bus_we && bus_sel == 2'd2 && bus_wdata[0]));

  assert_start_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bus_we && bus_sel == 2'd2 && bus_wdata[1]));

  assert_start_bod_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(bod_low));

  assert_abort_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abort_err) |-> $past(busy && bus_we && bus_sel[1] == 1'b0));

  assert_rd_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_we && bus_sel == 2'd2 && bus_wdata[0]) |=> !$rose(cpu_halt));

  assert_pd_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pd_ack |-> !busy);

  assert_pd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pd_req && busy) && pd_req) |-> !pd_ack);
endmodule

bind nvm_ctrl nvm_ctrl_chk #(.RD_STALL(RD_STALL)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_we   (bus_we),
  .bus_sel  (bus_sel),
  .bus_wdata(bus_wdata),
  .cpu_halt (cpu_halt),
  .bod_low  (bod_low),
  .pd_req   (pd_req),
  .pd_ack   (pd_ack),
  .busy     (busy),
  .abort_err(abort_err)
);

// File: tb/nvm_ctrl_bench.sv
`timescale 1ns/100ps
module nvm_ctrl_bench;
  localparam int AW = 4;
  localparam int TICKS = 40;
  localparam int NADDR = 1 << AW;
  localparam logic [1:0] S_ADDR = 2'd0, S_DATA = 2'd1, S_CTRL = 2'd2, S_STAT = 2'd3;

  logic clk = 1'b0, osc_clk = 1'b0, rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [1:0] bus_sel = 2'd0;
  logic [7:0] bus_wdata = 8'd0, bus_rdata;
  logic cpu_halt, bod_low = 1'b0, pd_req = 1'b0, pd_ack, osc_en;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] ref_mem [NADDR];
  bit ref_ok [NADDR];

  always #2.5 clk = ~clk;
  always #11.7 osc_clk = ~osc_clk;

  nvm_ctrl #(.AW(AW), .TICKS(TICKS), .RD_STALL(4), .ARM_WIN(4)) u_nvm_ctrl (
    .clk(clk), .rst_n(rst_n), .osc_clk(osc_clk), .bus_we(bus_we),
    .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_halt(cpu_halt), .bod_low(bod_low), .pd_req(pd_req),
    .pd_ack(pd_ack), .osc_en(osc_en)
  );

  function automatic logic [7:0] corrupt(input logic [7:0] d);
    return ~d;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bw(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_sel = s; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] v);
    bus_sel = s;
    #1;
    v = bus_rdata;
  endtask

  task automatic wait_idle(output int n);
    logic [7:0] st;
    n = 0;
    rd(S_STAT, st);
    while (st[0] && n < 2000) begin
      @(posedge osc_clk);
      n++;
      #0.1 rd(S_STAT, st);
    end
    @(negedge clk);
  endtask

  task automatic start_write(input logic [AW-1:0] a, input logic [7:0] d);
    bw(S_ADDR, 8'(a));
    bw(S_DATA, d);
    bw(S_CTRL, 8'h04);
    bw(S_CTRL, 8'h02);
  endtask

  task automatic full_write(input logic [AW-1:0] a, input logic [7:0] d);
    logic [7:0] v;
    int n;
    start_write(a, d);
    rd(S_CTRL, v);
    chk("R1 R3 ctrl write bit reads busy", 32'(v[1]), 1);
    wait_idle(n);
    chk("R5 busy length in window", 32'(n >= TICKS && n <= TICKS + 10), 1);
    ref_mem[a] = d; ref_ok[a] = 1;
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [7:0] v, output int stall);
    logic [7:0] c;
    bw(S_ADDR, 8'(a));
    bw(S_CTRL, 8'h01);
    rd(S_CTRL, c);
    chk("R2 read bit set during stall", 32'(c[0]), 1);
    stall = 0;
    while (cpu_halt && stall < 50) begin
      stall++;
      @(negedge clk);
    end
    rd(S_CTRL, c);
    chk("R2 read bit self-clears", 32'(c[0]), 0);
    rd(S_DATA, v);
  endtask

  task automatic read_check(input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] v;
    int s;
    do_read(a, v, s);
    chk("R2 halt length", s, 4);
    chk(tag, v, exp);
  endtask

  initial begin
    logic [7:0] v;
    int n;
    void'($urandom(32'h5eed_1234));
    foreach (ref_ok[i]) ref_ok[i] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(S_ADDR, v); chk("R10 addr reset", v, 0);
    rd(S_DATA, v); chk("R10 data reset", v, 0);
    rd(S_CTRL, v); chk("R10 ctrl reset", v, 0);
    rd(S_STAT, v); chk("R10 stat reset", v, 0);
    chk("R10 halt reset", 32'(cpu_halt), 0);
    chk("R10 osc_en reset", 32'(osc_en), 1);

    bw(S_ADDR, 8'h5A); rd(S_ADDR, v); chk("R1 addr upper bits zero", v, 8'h0A);
    bw(S_DATA, 8'h3C); rd(S_DATA, v); chk("R1 data readback", v, 8'h3C);

    full_write(4'd3, 8'hC5);
    read_check(4'd3, 8'hC5, "R2 R5 read after write");
    full_write(4'd0, 8'h00);
    full_write(4'd15, 8'hFF);
    read_check(4'd15, 8'hFF, "R5 top address");
    read_check(4'd0, 8'h00, "R5 bottom address");

    // arm window boundary: strobe 4 cycles after arm accepted
    bw(S_ADDR, 8'd5); bw(S_DATA, 8'h11);
    bw(S_CTRL, 8'h04);
    repeat (2) @(negedge clk);
    bw(S_CTRL, 8'h02);
    rd(S_STAT, v); chk("R3 strobe at window edge accepted", 32'(v[0]), 1);
    wait_idle(n);
    ref_mem[5] = 8'h11; ref_ok[5] = 1;

    // one cycle late: rejected
    bw(S_DATA, 8'h22);
    bw(S_CTRL, 8'h04);
    repeat (3) @(negedge clk);
    bw(S_CTRL, 8'h02);
    rd(S_STAT, v); chk("R3 R6 late strobe rejected", 32'(v[0]), 0);
    rd(S_CTRL, v); chk("R6 write bit self-clears", 32'(v[1]), 0);
    bw(S_CTRL, 8'h02);
    rd(S_STAT, v); chk("R6 unarmed strobe rejected", 32'(v[0]), 0);

    bod_low = 1'b1;
    bw(S_CTRL, 8'h04); bw(S_CTRL, 8'h02);
    rd(S_STAT, v); chk("R4 low supply blocks write", 32'(v[0]), 0);
    bod_low = 1'b0;

    rst_n = 1'b0;
    bw(S_CTRL, 8'h04); bw(S_CTRL, 8'h02);
    rst_n = 1'b1;
    @(negedge clk);
    rd(S_STAT, v); chk("R4 reset blocks write", 32'(v[0]), 0);
    read_check(4'd5, 8'h11, "R4 R6 array unchanged");

    // abort
    start_write(4'd7, 8'h6B);
    repeat (10) @(posedge osc_clk);
    bw(S_DATA, 8'h99);
    rd(S_STAT, v); chk("R7 abort flag", 32'(v[1]), 1);
    wait_idle(n);
    chk("R7 busy ends early", 32'(n < TICKS), 1);
    ref_mem[7] = corrupt(8'h6B); ref_ok[7] = 1;
    read_check(4'd7, corrupt(8'h6B), "R7 corrupted byte");
    bw(S_STAT, 8'h02);
    rd(S_STAT, v); chk("R1 abort flag cleared by write-one", 32'(v[1]), 0);

    // read collision
    start_write(4'd9, 8'h5E);
    repeat (7) @(posedge osc_clk);
    bw(S_CTRL, 8'h01);
    chk("R8 no halt while busy", 32'(cpu_halt), 0);
    rd(S_STAT, v); chk("R8 collision flag", 32'(v[2]), 1);
    rd(S_DATA, v); chk("R8 data unchanged", v, 8'h5E);
    wait_idle(n);
    ref_mem[9] = 8'h5E; ref_ok[9] = 1;
    read_check(4'd9, 8'h5E, "R8 write survives collision");
    bw(S_STAT, 8'h04);
    rd(S_STAT, v); chk("R1 collision flag cleared", 32'(v[2]), 0);

    // power-down during write
    start_write(4'd2, 8'h2D);
    repeat (5) @(posedge osc_clk);
    @(negedge clk);
    pd_req = 1'b1;
    @(negedge clk);
    chk("R9 no ack while busy", 32'(pd_ack), 0);
    wait_idle(n);
    ref_mem[2] = 8'h2D; ref_ok[2] = 1;
    chk("R9 ack held after write", 32'(pd_ack), 0);
    chk("R9 osc kept on", 32'(osc_en), 1);
    rd(S_STAT, v); chk("R9 hold status", 32'(v[3]), 1);
    pd_req = 1'b0;
    @(negedge clk); @(negedge clk);
    pd_req = 1'b1;
    #1;
    chk("R9 ack on re-request", 32'(pd_ack), 1);
    chk("R9 osc off", 32'(osc_en), 0);
    pd_req = 1'b0;
    @(negedge clk);

    // random mix
    for (int it = 0; it < 14; it++) begin
      int op;
      logic [AW-1:0] a;
      logic [7:0] d;
      op = int'($urandom % 3);
      a = AW'($urandom);
      d = 8'($urandom);
      if (op == 1 && ref_ok[a]) begin
        read_check(a, ref_mem[a], "R2 random read");
      end else if (op == 2) begin
        start_write(a, d);
        repeat (2 + int'($urandom % (TICKS - 8))) @(posedge osc_clk);
        bw(S_DATA, 8'($urandom));
        wait_idle(n);
        ref_mem[a] = corrupt(d); ref_ok[a] = 1;
        bw(S_STAT, 8'h06);
      end else begin
        full_write(a, d);
      end
    end

    for (int i = 0; i < NADDR; i++)
      if (ref_ok[i]) read_check(AW'(i), ref_mem[i], "R5 R7 final array");

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog R5 actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule